// File: doc/BRIEF.md
# On-Screen Display Serial Command Decoder

This block takes commands for a character overlay engine over a three-wire serial link: an active-low frame select, a shift clock and a data line. All three are brought into the system clock domain, and eight-bit words are assembled from them least significant bit first. The upper nibble of the first word of each frame chooses a command. Some commands are one word long and some are two. A write command can also run as an open-ended stream of character codes.

The decoder keeps the overlay's control registers. These are the sync and input setup, the port and attribute setup, the per-output enables and selects, the background and border, the display origin and three per-row flag maps. It also owns the write side of a 12 x 24 character memory. A cursor places each write and advances after it. A fill sequencer can blank the whole memory, but only while every output is disabled.

Top module: `osd_cmd_decoder`

## Requirements
- R1: A data bit is shifted in on each sampled rising edge of the shift clock while the frame select is low, least significant bit first. A frame select that goes high in the middle of a word throws away the bits taken so far.
- R2: The upper four bits of a first word form the command code. Codes 0-7 take one word and codes 8-13 take two. Codes 12, 13 and 7 change nothing. Any code whose top three bits are 111 is the write command. Raising the frame select makes the next word a first word again, even after only half of a two-word command.
- R3: The low nibble of a one-word command is stored as follows: code 1 to sync_cfg, code 2 to in_cfg (bit 1 = stream enable), code 3 to port_cfg, code 4 to attr_cfg, code 5 to out_en, code 6 to out_sel. For code 0, bit 1 goes to osc_stop and bit 0 to test_mode.
- R4: Code 8 loads bg_cfg = {first[2:0], second}. Code 9 loads start_pos = {first[3:0], second}.
- R5: Code 10 copies the low six bits of the second word into one half of each flag map picked by the first word. Bit 3 picks dbl_lines, bit 2 picks sys4_lines and bit 1 picks sys3_lines. Bit 0 picks rows 6-11 (1) or rows 0-5 (0).
- R6: Code 11 moves the cursor to row first[3:0] and column second[4:0]. The whole command is ignored if the row is above 11 or the column above 23.
- R7: The write command writes vram_wdata = {first[4:0], code} at vram_addr = row*24 + column. The code comes from the next word.
- R8: After each write the column advances. Column 23 wraps to column 0 on the next row, and row 11 column 23 wraps to address 0.
- R9: With the stream enable set, every word after the write command's first word is a code, and each is written with the same five attribute bits. The code 0xFF is not written; it ends the stream, and the next word is a first word.
- R10: Code 0 with bit 2 set fills all 288 cells with 0x0FE, one write every 4 clocks. clear_busy is high for exactly 1152 clocks and then drops by itself.
- R11: A fill request does nothing while out_en is nonzero.
- R12: Code 0 with bit 3 set returns every register, the cursor and the stream state to zero. The only exception is out_sel, which becomes 4'b0111.
- R13: After rst_n every register is zero except out_sel = 4'b0111, and no write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_cs_n | input | 1 | Serial frame select, active low |
| ser_clk | input | 1 | Serial shift clock |
| ser_din | input | 1 | Serial data |
| sync_cfg | output | 4 | Sync and clock setup |
| in_cfg | output | 4 | Input polarity and transfer format |
| port_cfg | output | 4 | Auxiliary pin setup |
| attr_cfg | output | 4 | Reverse and blink setup |
| out_en | output | 4 | Per-output enables |
| out_sel | output | 4 | Colour selection for outputs 3 and 4 |
| bg_cfg | output | 11 | Background colour and border modes |
| start_pos | output | 12 | Vertical and horizontal origin |
| dbl_lines | output | 12 | Double-size row flags |
| sys4_lines | output | 12 | Output-4 row flags |
| sys3_lines | output | 12 | Output-3 row flags |
| osc_stop | output | 1 | Oscillator stop request |
| test_mode | output | 1 | Test mode flag |
| vram_we | output | 1 | Character memory write strobe |
| vram_addr | output | 9 | Character memory address |
| vram_wdata | output | 13 | Attributes and code to write |
| clear_busy | output | 1 | Fill sequence in progress |

## Verification
The hardest situation to reach is a stream that crosses the last cell and wraps to address 0, and is then ended by the terminator inside the same frame, with another command following in that frame. The stimulus first turns on the stream enable. It then parks the cursor at row 11, column 23 and sends a single frame holding a write command, three codes, 0xFF and a one-word command. The captured write addresses, the write count and the later register value then show the wrap, the terminator and the return to command decoding.

// File: rtl/osd_cmd_pkg.sv
package osd_cmd_pkg;
  localparam int WORD_W = 8;
  localparam int ATTR_W = 5;
  localparam int DATA_W = ATTR_W + WORD_W;
  localparam logic [WORD_W-1:0] CODE_BLANK = 8'hFE;
  localparam logic [WORD_W-1:0] CODE_STOP  = 8'hFF;
  localparam logic [2:0]        WR_PREFIX  = 3'b111;
  localparam logic [3:0]        SEL_INIT   = 4'b0111;

  typedef enum logic [1:0] {
    DEC_CMD,
    DEC_ARG,
    DEC_STREAM
  } dec_st_e;
endpackage

// File: rtl/osd_ser_rx.sv
module osd_ser_rx
  import osd_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdin,
  output logic              byte_vld,
  output logic [WORD_W-1:0] byte_q,
  output logic              frame_off
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [SYNC_STAGES-1:0] cs_s, ck_s, d_s;
  logic                   ck_prev;
  logic [WORD_W-1:0]      shift_q, shift_n;
  logic [CNT_W-1:0]       cnt_q, cnt_n;
  logic                   vld_q, vld_n;
  logic                   cs_q, ck_q, d_q, rise;

  assign cs_q = cs_s[SYNC_STAGES-1];
  assign ck_q = ck_s[SYNC_STAGES-1];
  assign d_q  = d_s[SYNC_STAGES-1];
  assign rise = ck_q & ~ck_prev & ~cs_q;

  always_comb begin
    shift_n = shift_q;
    cnt_n   = cnt_q;
    vld_n   = 1'b0;
    if (cs_q) begin
      cnt_n = '0;
    end else if (rise) begin
      shift_n = {d_q, shift_q[WORD_W-1:1]};
      if (cnt_q == LAST_BIT) begin
        cnt_n = '0;
        vld_n = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s    <= '1;
      ck_s    <= '0;
      d_s     <= '0;
      ck_prev <= 1'b0;
      shift_q <= '0;
      cnt_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      cs_s    <= {cs_s[SYNC_STAGES-2:0], cs_n};
      ck_s    <= {ck_s[SYNC_STAGES-2:0], sclk};
      d_s     <= {d_s[SYNC_STAGES-2:0], sdin};
      ck_prev <= ck_q;
      shift_q <= shift_n;
      cnt_q   <= cnt_n;
      vld_q   <= vld_n;
    end
  end

  assign byte_vld  = vld_q;
  assign byte_q    = shift_q;
  assign frame_off = cs_q;

  // R1
  word_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> !$past(cs_q));
endmodule

// File: rtl/osd_cmd_dec.sv
module osd_cmd_dec
  import osd_cmd_pkg::*;
#(
  parameter int ROWS = 12,
  parameter int COLS = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [WORD_W-1:0] byte_q,
  input  logic              frame_off,
  output logic [3:0]        sync_cfg,
  output logic [3:0]        in_cfg,
  output logic [3:0]        port_cfg,
  output logic [3:0]        attr_cfg,
  output logic [3:0]        out_en,
  output logic [3:0]        out_sel,
  output logic [10:0]       bg_cfg,
  output logic [11:0]       start_pos,
  output logic [ROWS-1:0]   dbl_lines,
  output logic [ROWS-1:0]   sys4_lines,
  output logic [ROWS-1:0]   sys3_lines,
  output logic              osc_stop,
  output logic              test_mode,
  output logic              sys_rst_p,
  output logic              clr_req,
  output logic              set_cur,
  output logic [$clog2(ROWS)-1:0] cur_row,
  output logic [$clog2(COLS)-1:0] cur_col,
  output logic              wr_req,
  output logic [DATA_W-1:0] wr_data
);
  localparam int HALF  = ROWS / 2;
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);
  localparam logic [ROW_W-1:0] ROW_LIM = ROW_W'(ROWS - 1);
  localparam logic [COL_W-1:0] COL_LIM = COL_W'(COLS - 1);

  dec_st_e           st_q, st_n;
  logic [WORD_W-1:0] b0_q, b0_n;
  logic [ATTR_W-1:0] attr_q, attr_n;
  logic [3:0]  sync_n, in_n, port_n, acfg_n, en_n, sel_n;
  logic [10:0] bg_n;
  logic [11:0] pos_n;
  logic [ROWS-1:0] dbl_n, s4_n, s3_n;
  logic osc_n, test_n;
  logic [HALF-1:0] lbits;

  assign lbits   = byte_q[HALF-1:0];
  assign cur_row = b0_q[ROW_W-1:0];
  assign cur_col = byte_q[COL_W-1:0];
  assign wr_data = {attr_q, byte_q};

  always_comb begin
    st_n = st_q;  b0_n = b0_q;  attr_n = attr_q;
    sync_n = sync_cfg;  in_n = in_cfg;  port_n = port_cfg;
    acfg_n = attr_cfg;  en_n = out_en;  sel_n = out_sel;
    bg_n = bg_cfg;  pos_n = start_pos;
    dbl_n = dbl_lines;  s4_n = sys4_lines;  s3_n = sys3_lines;
    osc_n = osc_stop;  test_n = test_mode;
    sys_rst_p = 1'b0;  clr_req = 1'b0;  set_cur = 1'b0;  wr_req = 1'b0;
    if (byte_vld) begin
      unique case (st_q)
        DEC_CMD: begin
          if (byte_q[7:5] == WR_PREFIX) begin
            attr_n = byte_q[ATTR_W-1:0];
            b0_n   = byte_q;
            st_n   = in_cfg[1] ? DEC_STREAM : DEC_ARG;
          end else if (byte_q[7]) begin
            b0_n = byte_q;
            st_n = DEC_ARG;
          end else begin
            unique case (byte_q[6:4])
              3'd0: begin
                if (byte_q[3]) begin
                  sys_rst_p = 1'b1;
                end else begin
                  osc_n   = byte_q[1];
                  test_n  = byte_q[0];
                  clr_req = byte_q[2];
                end
              end
              3'd1: sync_n = byte_q[3:0];
              3'd2: in_n   = byte_q[3:0];
              3'd3: port_n = byte_q[3:0];
              3'd4: acfg_n = byte_q[3:0];
              3'd5: en_n   = byte_q[3:0];
              3'd6: sel_n  = byte_q[3:0];
              default: ;
            endcase
          end
        end
        DEC_ARG: begin
          st_n = DEC_CMD;
          unique case (b0_q[7:4])
            4'd8: bg_n  = {b0_q[2:0], byte_q};
            4'd9: pos_n = {b0_q[3:0], byte_q};
            4'd10: begin
              if (b0_q[3]) begin
                if (b0_q[0]) dbl_n[HALF +: HALF] = lbits;
                else         dbl_n[0 +: HALF]    = lbits;
              end
              if (b0_q[2]) begin
                if (b0_q[0]) s4_n[HALF +: HALF] = lbits;
                else         s4_n[0 +: HALF]    = lbits;
              end
              if (b0_q[1]) begin
                if (b0_q[0]) s3_n[HALF +: HALF] = lbits;
                else         s3_n[0 +: HALF]    = lbits;
              end
            end
            4'd11: begin
              if (cur_row <= ROW_LIM && cur_col <= COL_LIM) set_cur = 1'b1;
            end
            4'd14, 4'd15: wr_req = 1'b1;
            default: ;
          endcase
        end
        DEC_STREAM: begin
          if (byte_q == CODE_STOP) st_n = DEC_CMD;
          else                     wr_req = 1'b1;
        end
        default: st_n = DEC_CMD;
      endcase
    end
    if (frame_off) st_n = DEC_CMD;
    if (sys_rst_p) begin
      st_n = DEC_CMD;  b0_n = '0;  attr_n = '0;
      sync_n = '0;  in_n = '0;  port_n = '0;  acfg_n = '0;  en_n = '0;
      sel_n = SEL_INIT;  bg_n = '0;  pos_n = '0;
      dbl_n = '0;  s4_n = '0;  s3_n = '0;  osc_n = 1'b0;  test_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= DEC_CMD;  b0_q <= '0;  attr_q <= '0;
      sync_cfg <= '0;  in_cfg <= '0;  port_cfg <= '0;  attr_cfg <= '0;
      out_en <= '0;  out_sel <= SEL_INIT;  bg_cfg <= '0;  start_pos <= '0;
      dbl_lines <= '0;  sys4_lines <= '0;  sys3_lines <= '0;
      osc_stop <= 1'b0;  test_mode <= 1'b0;
    end else begin
      st_q <= st_n;  b0_q <= b0_n;  attr_q <= attr_n;
      sync_cfg <= sync_n;  in_cfg <= in_n;  port_cfg <= port_n;  attr_cfg <= acfg_n;
      out_en <= en_n;  out_sel <= sel_n;  bg_cfg <= bg_n;  start_pos <= pos_n;
      dbl_lines <= dbl_n;  sys4_lines <= s4_n;  sys3_lines <= s3_n;
      osc_stop <= osc_n;  test_mode <= test_n;
    end
  end

  // R12
  sysreset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_p |=> (out_sel == SEL_INIT && out_en == 4'd0 && in_cfg == 4'd0 && dbl_lines == '0));

  // R2
  cs_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_off |=> st_q == DEC_CMD);
endmodule

// File: rtl/osd_vram_wr.sv
module osd_vram_wr
  import osd_cmd_pkg::*;
#(
  parameter int ROWS    = 12,
  parameter int COLS    = 24,
  parameter int CLR_CYC = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            sys_rst_p,
  input  logic                            set_cur,
  input  logic [$clog2(ROWS)-1:0]         set_row,
  input  logic [$clog2(COLS)-1:0]         set_col,
  input  logic                            wr_req,
  input  logic [DATA_W-1:0]               wr_data,
  input  logic                            clr_req,
  input  logic                            disp_on,
  output logic                            vram_we,
  output logic [$clog2(ROWS*COLS)-1:0]    vram_addr,
  output logic [DATA_W-1:0]               vram_wdata,
  output logic                            clr_busy
);
  localparam int CELLS  = ROWS * COLS;
  localparam int ADDR_W = $clog2(CELLS);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int COL_W  = $clog2(COLS);
  localparam int SLOT_W = $clog2(CLR_CYC);
  localparam logic [ROW_W-1:0]  ROW_LIM  = ROW_W'(ROWS - 1);
  localparam logic [COL_W-1:0]  COL_LIM  = COL_W'(COLS - 1);
  localparam logic [ADDR_W-1:0] COLS_A   = ADDR_W'(COLS);
  localparam logic [ADDR_W-1:0] CELL_LIM = ADDR_W'(CELLS - 1);
  localparam logic [SLOT_W-1:0] SLOT_LIM = SLOT_W'(CLR_CYC - 1);
  localparam logic [DATA_W-1:0] FILL_WORD = {{ATTR_W{1'b0}}, CODE_BLANK};

  logic [ROW_W-1:0]  row_q, row_n;
  logic [COL_W-1:0]  col_q, col_n;
  logic [ADDR_W-1:0] idx_q, idx_n, addr_n, cur_addr;
  logic [SLOT_W-1:0] slot_q, slot_n;
  logic              busy_n, we_n;
  logic [DATA_W-1:0] data_n;

  assign cur_addr = ADDR_W'(row_q) * COLS_A + ADDR_W'(col_q);

  always_comb begin
    row_n = row_q;  col_n = col_q;
    idx_n = idx_q;  slot_n = slot_q;  busy_n = clr_busy;
    we_n = 1'b0;  addr_n = vram_addr;  data_n = vram_wdata;
    if (clr_busy) begin
      if (slot_q == SLOT_LIM) begin
        slot_n = '0;
        we_n   = 1'b1;
        addr_n = idx_q;
        data_n = FILL_WORD;
        if (idx_q == CELL_LIM) busy_n = 1'b0;
        else                   idx_n  = idx_q + 1'b1;
      end else begin
        slot_n = slot_q + 1'b1;
      end
    end else if (clr_req && !disp_on) begin
      busy_n = 1'b1;
      idx_n  = '0;
      slot_n = '0;
    end else if (set_cur) begin
      row_n = set_row;
      col_n = set_col;
    end else if (wr_req) begin
      we_n   = 1'b1;
      addr_n = cur_addr;
      data_n = wr_data;
      if (col_q == COL_LIM) begin
        col_n = '0;
        row_n = (row_q == ROW_LIM) ? '0 : row_q + 1'b1;
      end else begin
        col_n = col_q + 1'b1;
      end
    end
    if (sys_rst_p) begin
      row_n = '0;  col_n = '0;  busy_n = 1'b0;  we_n = 1'b0;
      idx_n = '0;  slot_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;  col_q <= '0;  idx_q <= '0;  slot_q <= '0;
      clr_busy <= 1'b0;  vram_we <= 1'b0;  vram_addr <= '0;  vram_wdata <= '0;
    end else begin
      row_q <= row_n;  col_q <= col_n;  idx_q <= idx_n;  slot_q <= slot_n;
      clr_busy <= busy_n;  vram_we <= we_n;  vram_addr <= addr_n;  vram_wdata <= data_n;
    end
  end

  // R8
  addr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vram_we |-> vram_addr <= CELL_LIM);

  // R6
  cursor_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_q <= ROW_LIM && col_q <= COL_LIM);

  // R11
  clear_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr_busy) |-> !$past(disp_on));

  // R10
  clear_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vram_we && $past(clr_busy) && !$past(sys_rst_p)) |-> vram_wdata == FILL_WORD);
endmodule

// File: rtl/osd_cmd_decoder.sv
module osd_cmd_decoder
  import osd_cmd_pkg::*;
#(
  parameter int ROWS        = 12,
  parameter int COLS        = 24,
  parameter int CLR_CYC     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ser_cs_n,
  input  logic                         ser_clk,
  input  logic                         ser_din,
  output logic [3:0]                   sync_cfg,
  output logic [3:0]                   in_cfg,
  output logic [3:0]                   port_cfg,
  output logic [3:0]                   attr_cfg,
  output logic [3:0]                   out_en,
  output logic [3:0]                   out_sel,
  output logic [10:0]                  bg_cfg,
  output logic [11:0]                  start_pos,
  output logic [ROWS-1:0]              dbl_lines,
  output logic [ROWS-1:0]              sys4_lines,
  output logic [ROWS-1:0]              sys3_lines,
  output logic                         osc_stop,
  output logic                         test_mode,
  output logic                         vram_we,
  output logic [$clog2(ROWS*COLS)-1:0] vram_addr,
  output logic [DATA_W-1:0]            vram_wdata,
  output logic                         clear_busy
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);

  logic [1:0]        rst_pipe;
  logic              rst_i_n;
  logic              byte_vld, frame_off;
  logic [WORD_W-1:0] byte_q;
  logic              sys_rst_p, clr_req, set_cur, wr_req;
  logic [ROW_W-1:0]  cur_row;
  logic [COL_W-1:0]  cur_col;
  logic [DATA_W-1:0] wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  osd_ser_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_i_n), .cs_n(ser_cs_n), .sclk(ser_clk), .sdin(ser_din),
    .byte_vld(byte_vld), .byte_q(byte_q), .frame_off(frame_off)
  );

  osd_cmd_dec #(.ROWS(ROWS), .COLS(COLS)) u_dec (
    .clk(clk), .rst_n(rst_i_n), .byte_vld(byte_vld), .byte_q(byte_q),
    .frame_off(frame_off), .sync_cfg(sync_cfg), .in_cfg(in_cfg),
    .port_cfg(port_cfg), .attr_cfg(attr_cfg), .out_en(out_en), .out_sel(out_sel),
    .bg_cfg(bg_cfg), .start_pos(start_pos), .dbl_lines(dbl_lines),
    .sys4_lines(sys4_lines), .sys3_lines(sys3_lines), .osc_stop(osc_stop),
    .test_mode(test_mode), .sys_rst_p(sys_rst_p), .clr_req(clr_req),
    .set_cur(set_cur), .cur_row(cur_row), .cur_col(cur_col),
    .wr_req(wr_req), .wr_data(wr_data)
  );

  osd_vram_wr #(.ROWS(ROWS), .COLS(COLS), .CLR_CYC(CLR_CYC)) u_wr (
    .clk(clk), .rst_n(rst_i_n), .sys_rst_p(sys_rst_p), .set_cur(set_cur),
    .set_row(cur_row), .set_col(cur_col), .wr_req(wr_req), .wr_data(wr_data),
    .clr_req(clr_req), .disp_on(|out_en), .vram_we(vram_we),
    .vram_addr(vram_addr), .vram_wdata(vram_wdata), .clr_busy(clear_busy)
  );
endmodule

// File: tb/sim_osd_cmd_decoder.sv
module sim_osd_cmd_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  always #5 clk = ~clk;

  logic [3:0] sync_cfg, in_cfg, port_cfg, attr_cfg, out_en, out_sel;
  logic [10:0] bg_cfg;
  logic [11:0] start_pos, dbl_lines, sys4_lines, sys3_lines;
  logic osc_stop, test_mode, vram_we, clear_busy;
  logic [8:0] vram_addr;
  logic [12:0] vram_wdata;

  osd_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .ser_cs_n(cs_n), .ser_clk(sck), .ser_din(sdi),
    .sync_cfg(sync_cfg), .in_cfg(in_cfg), .port_cfg(port_cfg), .attr_cfg(attr_cfg),
    .out_en(out_en), .out_sel(out_sel), .bg_cfg(bg_cfg), .start_pos(start_pos),
    .dbl_lines(dbl_lines), .sys4_lines(sys4_lines), .sys3_lines(sys3_lines),
    .osc_stop(osc_stop), .test_mode(test_mode), .vram_we(vram_we),
    .vram_addr(vram_addr), .vram_wdata(vram_wdata), .clear_busy(clear_busy)
  );

  logic [12:0] mem [0:287];
  int wr_cnt = 0, busy_cnt = 0;
  logic [8:0] last_addr = '0;
  logic [12:0] last_data = '0;
  always @(posedge clk) begin
    if (vram_we) begin
      if (vram_addr < 9'd288) mem[vram_addr] <= vram_wdata;
      last_addr <= vram_addr;
      last_data <= vram_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (clear_busy) busy_cnt <= busy_cnt + 1;
  end

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sdi = b[i];
      tick(4);
      sck = 1'b1;
      tick(4);
      sck = 1'b0;
    end
  endtask

  task automatic open_f();  cs_n = 1'b0; tick(4); endtask
  task automatic close_f(); tick(4); cs_n = 1'b1; tick(12); endtask
  task automatic frame1(input logic [7:0] a); open_f(); send_bits(a, 8); close_f(); endtask
  task automatic frame2(input logic [7:0] a, input logic [7:0] b);
    open_f(); send_bits(a, 8); send_bits(b, 8); close_f();
  endtask

  function automatic logic [11:0] pick(input logic [3:0] s);
    case (s)
      4'd0: pick = {8'd0, sync_cfg};
      4'd1: pick = {8'd0, in_cfg};
      4'd2: pick = {8'd0, port_cfg};
      4'd3: pick = {8'd0, attr_cfg};
      4'd5: pick = {8'd0, out_sel};
      4'd6: pick = {1'b0, bg_cfg};
      4'd7: pick = start_pos;
      4'd8: pick = dbl_lines;
      4'd9: pick = sys4_lines;
      4'd10: pick = sys3_lines;
      4'd11: pick = {10'd0, osc_stop, test_mode};
      default: pick = '0;
    endcase
  endfunction

  typedef struct packed {
    logic [7:0]  b0;
    logic [7:0]  b1;
    logic        two;
    logic [3:0]  sel;
    logic [3:0]  req;
    logic [11:0] exp;
  } vec_t;

  // R3 one-word loads, R4 two-word loads, R5 row maps, R2 inert codes
  localparam vec_t VEC [0:12] = '{
    '{8'h1A, 8'h00, 1'b0, 4'd0,  4'd3, 12'h00A},
    '{8'h25, 8'h00, 1'b0, 4'd1,  4'd3, 12'h005},
    '{8'h3C, 8'h00, 1'b0, 4'd2,  4'd3, 12'h00C},
    '{8'h4B, 8'h00, 1'b0, 4'd3,  4'd3, 12'h00B},
    '{8'h66, 8'h00, 1'b0, 4'd5,  4'd3, 12'h006},
    '{8'h85, 8'hA5, 1'b1, 4'd6,  4'd4, 12'h5A5},
    '{8'h9E, 8'h3F, 1'b1, 4'd7,  4'd4, 12'hE3F},
    '{8'hA8, 8'h05, 1'b1, 4'd8,  4'd5, 12'h005},
    '{8'hA9, 8'h22, 1'b1, 4'd8,  4'd5, 12'h885},
    '{8'hA5, 8'h3F, 1'b1, 4'd9,  4'd5, 12'hFC0},
    '{8'h03, 8'h00, 1'b0, 4'd11, 4'd3, 12'h003},
    '{8'h7F, 8'h00, 1'b0, 4'd5,  4'd2, 12'h006},
    '{8'hC0, 8'hFF, 1'b1, 4'd6,  4'd2, 12'h5A5}
  };

  initial begin
    int w0, b0;
    tick(5);
    rst_n = 1'b1;
    tick(10);
    // R13 reset state
    chk("R13 sync_cfg", sync_cfg, 0);
    chk("R13 out_sel", out_sel, 4'b0111);
    chk("R13 out_en", out_en, 0);
    chk("R13 start_pos", start_pos, 0);
    chk("R13 writes", wr_cnt, 0);
    chk("R13 clear_busy", clear_busy, 0);

    for (int i = 0; i < 13; i++) begin
      if (VEC[i].two) frame2(VEC[i].b0, VEC[i].b1);
      else            frame1(VEC[i].b0);
      chk($sformatf("R%0d vector %0d", VEC[i].req, i), pick(VEC[i].sel), VEC[i].exp);
    end

    // R1 partial word dropped
    open_f(); send_bits(8'hFF, 5); close_f();
    frame1(8'h13);
    chk("R1 partial word", sync_cfg, 4'h3);

    // R2 half command abandoned by frame end
    frame1(8'h91);
    frame1(8'h12);
    chk("R2 restart sync", sync_cfg, 4'h2);
    chk("R2 restart pos", start_pos, 12'hE3F);

    // R6 R7 cursor and writes
    frame2(8'hB1, 8'h16);
    frame2(8'hF5, 8'h41);
    chk("R7 addr", last_addr, 46);
    chk("R7 data", last_data, 13'h1541);
    frame2(8'hE3, 8'h42);
    chk("R8 addr next", last_addr, 47);
    chk("R7 data2", last_data, 13'h0342);
    frame2(8'hE0, 8'h43);
    chk("R8 column wrap", last_addr, 48);

    // R6 out-of-range cursor ignored
    frame2(8'hBC, 8'h05);
    frame2(8'hB0, 8'h18);
    frame2(8'hE0, 8'h44);
    chk("R6 bad cursor ignored", last_addr, 49);

    // R9 stream wrapping past last cell, terminated, then a command
    frame1(8'h22);
    frame2(8'hBB, 8'h17);
    w0 = wr_cnt;
    open_f();
    send_bits(8'hE4, 8); send_bits(8'h10, 8); send_bits(8'h11, 8);
    send_bits(8'h12, 8); send_bits(8'hFF, 8); send_bits(8'h19, 8);
    close_f();
    chk("R9 stream writes", wr_cnt - w0, 3);
    chk("R9 cell 287", mem[287], 13'h0410);
    chk("R8 wrap to 0", mem[0], 13'h0411);
    chk("R9 cell 1", mem[1], 13'h0412);
    chk("R9 after stop", sync_cfg, 4'h9);

    // R11 fill refused with an output on
    frame1(8'h51);
    w0 = wr_cnt;
    frame1(8'h04);
    tick(50);
    chk("R11 busy", clear_busy, 0);
    chk("R11 writes", wr_cnt - w0, 0);
    chk("R11 cell kept", mem[46], 13'h1541);

    // R10 fill
    frame1(8'h50);
    w0 = wr_cnt;
    b0 = busy_cnt;
    frame1(8'h04);
    for (int k = 0; k < 3000 && clear_busy; k++) tick(1);
    tick(2);
    chk("R10 busy cycles", busy_cnt - b0, 1152);
    chk("R10 fill writes", wr_cnt - w0, 288);
    chk("R10 cell 0", mem[0], 13'h00FE);
    chk("R10 cell 287", mem[287], 13'h00FE);
    chk("R10 cell 46", mem[46], 13'h00FE);

    // R12 command reset
    frame1(8'h08);
    chk("R12 sync", sync_cfg, 0);
    chk("R12 out_sel", out_sel, 4'b0111);
    chk("R12 in_cfg", in_cfg, 0);
    chk("R12 bg", bg_cfg, 0);
    chk("R12 dbl", dbl_lines, 0);
    frame2(8'hE0, 8'h55);
    chk("R12 cursor home", last_addr, 0);
    chk("R12 data", last_data, 13'h0055);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule